// File: doc/BRIEF.md
# Prefetch Request Queue and Fetch Unit Scheduler

This block sits in a non-blocking data cache between the sources of prefetch requests and the pool of fetch units that move cache blocks in from the next memory level. Every prefetch that missed in the cache goes into a first-in, first-out queue of block addresses. This applies to scalar prefetch requests and to requests raised by a stream table. A prefetch that hit in the cache is dropped at the door. When the queue is full, a new request is discarded. A later demand miss still fetches the block, so nothing breaks functionally.

The queue releases its oldest entry only in a cycle with no CPU cache operation and no load miss. A fetch unit must also be free, and the number of units already busy with prefetches must be below a cap. The released address is looked up in the tags once more. If it now hits, it is dropped and no unit is taken. Load misses are granted a fetch unit ahead of any queued prefetch. On the shared memory bus, units that serve load misses win over units that serve prefetches. A unit stays busy from its allocation until the last data of its block arrives. Two saturating counters record discarded requests and issued prefetch fetches.

Top module: `pf_fetch_sched`

## Requirements
- R1: A request with `pf_req_hit`=1 is not queued and never leads to a fetch start.
- R2: A prefetch miss never starts a fetch in the cycle it arrives. It only starts from the queue, in a later cycle, even if a unit is free.
- R3: A miss that arrives while the queue holds DEPTH entries is discarded and adds one to `drop_cnt`. Fullness is judged at the start of the cycle, even if the head leaves in that same cycle.
- R4: The head leaves the queue only in a cycle with `cpu_op`=0, `ld_miss_valid`=0, a free unit, and fewer than PF_MAX units busy with prefetches.
- R5: At most PF_MAX (default 2 of 4) fetch units are busy with prefetches at any time.
- R6: A load miss is granted (`ld_miss_gnt`=1) whenever a unit is free. It takes the lowest-numbered free unit and `fu_start_pf`=0 for it.
- R7: If `tag_chk_hit`=1 while the head leaves, the head is dropped with no fetch start, and `drop_cnt` gains one.
- R8: `fu_start` is one-hot or zero and names the lowest free unit. A unit becomes free in the cycle after its `fu_done` bit is 1.
- R9: `fu_bus_gnt` is one-hot or zero and goes only to a busy, requesting unit. Load units win over prefetch units, and the lower index wins within a class.
- R10: `drop_cnt` and `issue_cnt` saturate at all ones. `issue_cnt` counts prefetch fetch starts.
- R11: Queued prefetches start in arrival order, with the address presented on `fu_start_addr`.
- R12: After reset the queue is empty, all units are free, both counters are zero, and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 1 | CPU issues a cache operation this cycle |
| pf_req_valid | input | 1 | Prefetch request present |
| pf_req_hit | input | 1 | Prefetch request hit in the cache |
| pf_req_addr | input | ADDR_W | Prefetch block address |
| ld_miss_valid | input | 1 | Load miss needs a fetch unit |
| ld_miss_addr | input | ADDR_W | Load miss block address |
| ld_miss_gnt | output | 1 | Load miss got a unit this cycle |
| tag_chk_addr | output | ADDR_W | Queue head address for tag recheck |
| tag_chk_hit | input | 1 | Tag recheck result for the head |
| fu_start | output | NUM_FU | One-hot unit started this cycle |
| fu_start_addr | output | ADDR_W | Block address for the started unit |
| fu_start_pf | output | 1 | Started unit serves a prefetch |
| fu_done | input | NUM_FU | Last data of the block arrived, per unit |
| fu_busy | output | NUM_FU | Unit is allocated |
| fu_bus_req | input | NUM_FU | Unit requests the memory bus |
| fu_bus_gnt | output | NUM_FU | Memory bus grant |
| drop_cnt | output | CNT_W | Saturating count of discarded requests |
| issue_cnt | output | CNT_W | Saturating count of prefetch fetch starts |

## Verification
Two kinds of drop can fall in one cycle: an overflow discard and a tag-hit drop of the head as it leaves. The bench fills the queue with the CPU busy. It then frees the CPU, offers one more miss and raises `tag_chk_hit` together. It expects no fetch start and `drop_cnt` to rise by two. A load miss and a ready queue head can also meet in one cycle; the stimulus table sets that up and expects the unit to go to the load while the head waits.

// File: rtl/pf_sched_pkg.sv
package pf_sched_pkg;
   typedef enum logic {
      FU_KIND_LOAD = 1'b0,
      FU_KIND_PREF = 1'b1
   } fu_kind_e;

   localparam int unsigned DROP_INC_W = 2;
endpackage

// File: rtl/pf_sched_fifo.sv
module pf_sched_fifo #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [ADDR_W-1:0]           push_addr,
   input  logic                        pop,
   output logic                        head_vld,
   output logic [ADDR_W-1:0]           head_addr,
   output logic                        full,
   output logic [$clog2(DEPTH+1)-1:0]  count
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH+1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULLC = CW'(DEPTH);

   logic [ADDR_W-1:0] slot [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign full      = (count == FULLC);
   assign head_vld  = (count != '0);
   assign head_addr = slot[rd_ptr];
   assign do_push   = push && !full;
   assign do_pop    = pop && head_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) begin
            slot[wr_ptr] <= push_addr;
            wr_ptr       <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (do_pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/pf_sched_fu_pool.sv
module pf_sched_fu_pool
   import pf_sched_pkg::*;
#(
   parameter int unsigned NUM_FU = 4,
   parameter int unsigned PF_MAX = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_vld,
   input  fu_kind_e          alloc_kind,
   input  logic [NUM_FU-1:0] done,
   output logic [NUM_FU-1:0] alloc_onehot,
   output logic              free_any,
   output logic              pf_room,
   output logic [NUM_FU-1:0] busy,
   output logic [NUM_FU-1:0] is_pf
);
   localparam int unsigned NW = $clog2(NUM_FU+1);

   logic [NUM_FU-1:0] pick;
   logic [NW-1:0]     pf_busy_n;

   always_comb begin
      pick = '0;
      for (int i = NUM_FU-1; i >= 0; i--)
         if (!busy[i]) pick = NUM_FU'(1) << i;
   end

   always_comb begin
      pf_busy_n = '0;
      for (int i = 0; i < NUM_FU; i++)
         pf_busy_n = pf_busy_n + NW'(busy[i] && is_pf[i]);
   end

   assign free_any     = (pick != '0);
   assign pf_room      = (pf_busy_n < NW'(PF_MAX));
   assign alloc_onehot = alloc_vld ? pick : '0;

   for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy[g]  <= 1'b0;
            is_pf[g] <= 1'b0;
         end else if (alloc_onehot[g]) begin
            busy[g]  <= 1'b1;
            is_pf[g] <= (alloc_kind == FU_KIND_PREF);
         end else if (done[g]) begin
            busy[g]  <= 1'b0;
            is_pf[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pf_sched_bus_arb.sv
module pf_sched_bus_arb #(
   parameter int unsigned NUM_FU     = 4,
   parameter bit          LOAD_FIRST = 1'b1
) (
   input  logic [NUM_FU-1:0] req,
   input  logic [NUM_FU-1:0] busy,
   input  logic [NUM_FU-1:0] is_pf,
   output logic [NUM_FU-1:0] gnt
);
   logic [NUM_FU-1:0] elig;
   assign elig = req & busy;

   function automatic logic [NUM_FU-1:0] lowest(input logic [NUM_FU-1:0] v);
      logic [NUM_FU-1:0] r;
      r = '0;
      for (int i = NUM_FU-1; i >= 0; i--)
         if (v[i]) r = NUM_FU'(1) << i;
      return r;
   endfunction

   if (LOAD_FIRST) begin : g_class
      logic [NUM_FU-1:0] ld_elig;
      assign ld_elig = elig & ~is_pf;
      assign gnt = (ld_elig != '0) ? lowest(ld_elig) : lowest(elig);
   end else begin : g_flat
      assign gnt = lowest(elig);
   end
endmodule

// File: rtl/pf_sched_sat_ctr.sv
module pf_sched_sat_ctr
   import pf_sched_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DROP_INC_W-1:0] inc,
   output logic [W-1:0]          cnt
);
   logic [W+DROP_INC_W-1:0] sum;
   logic [W-1:0]            nxt;

   always_comb begin
      sum = {{DROP_INC_W{1'b0}}, cnt} + {{W{1'b0}}, inc};
      nxt = (sum[W+DROP_INC_W-1:W] != '0) ? '1 : sum[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/pf_fetch_sched.sv
module pf_fetch_sched
   import pf_sched_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned NUM_FU     = 4,
   parameter int unsigned PF_MAX     = 2,
   parameter int unsigned CNT_W      = 8,
   parameter bit          LOAD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_op,
   input  logic              pf_req_valid,
   input  logic              pf_req_hit,
   input  logic [ADDR_W-1:0] pf_req_addr,
   input  logic              ld_miss_valid,
   input  logic [ADDR_W-1:0] ld_miss_addr,
   output logic              ld_miss_gnt,
   output logic [ADDR_W-1:0] tag_chk_addr,
   input  logic              tag_chk_hit,
   output logic [NUM_FU-1:0] fu_start,
   output logic [ADDR_W-1:0] fu_start_addr,
   output logic              fu_start_pf,
   input  logic [NUM_FU-1:0] fu_done,
   output logic [NUM_FU-1:0] fu_busy,
   input  logic [NUM_FU-1:0] fu_bus_req,
   output logic [NUM_FU-1:0] fu_bus_gnt,
   output logic [CNT_W-1:0]  drop_cnt,
   output logic [CNT_W-1:0]  issue_cnt
);
   localparam int unsigned CW = $clog2(DEPTH+1);

   if (DEPTH < 2)       begin : g_bad_depth  $error("DEPTH must be at least 2");    end
   if (NUM_FU < 1)      begin : g_bad_nfu    $error("NUM_FU must be at least 1");   end
   if (PF_MAX < 1 || PF_MAX > NUM_FU)
                        begin : g_bad_pfmax  $error("PF_MAX must lie in 1..NUM_FU"); end
   if (CNT_W < 2)       begin : g_bad_cnt    $error("CNT_W must be at least 2");    end

   logic              q_push, q_pop, q_head_vld, q_full;
   logic [ADDR_W-1:0] q_head_addr;
   logic [CW-1:0]     q_count;
   logic              free_any, pf_room;
   logic [NUM_FU-1:0] fu_is_pf;
   logic              drain, pf_issue, pf_tagdrop, overflow, alloc_vld;
   fu_kind_e          alloc_kind;
   logic [DROP_INC_W-1:0] drop_inc, issue_inc;

   assign q_push      = pf_req_valid && !pf_req_hit;
   assign overflow    = q_push && q_full;
   assign ld_miss_gnt = ld_miss_valid && free_any;
   assign drain       = q_head_vld && !cpu_op && !ld_miss_valid && free_any && pf_room;
   assign q_pop       = drain;
   assign pf_issue    = drain && !tag_chk_hit;
   assign pf_tagdrop  = drain && tag_chk_hit;
   assign alloc_vld   = ld_miss_gnt || pf_issue;
   assign alloc_kind  = ld_miss_gnt ? FU_KIND_LOAD : FU_KIND_PREF;
   assign fu_start_addr = ld_miss_gnt ? ld_miss_addr : q_head_addr;
   assign fu_start_pf   = pf_issue;
   assign tag_chk_addr  = q_head_addr;
   assign drop_inc    = DROP_INC_W'(overflow) + DROP_INC_W'(pf_tagdrop);
   assign issue_inc   = DROP_INC_W'(pf_issue);

   pf_sched_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_addr(pf_req_addr), .pop(q_pop),
      .head_vld(q_head_vld), .head_addr(q_head_addr),
      .full(q_full), .count(q_count)
   );

   pf_sched_fu_pool #(.NUM_FU(NUM_FU), .PF_MAX(PF_MAX)) pool_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_kind(alloc_kind), .done(fu_done),
      .alloc_onehot(fu_start), .free_any(free_any), .pf_room(pf_room),
      .busy(fu_busy), .is_pf(fu_is_pf)
   );

   pf_sched_bus_arb #(.NUM_FU(NUM_FU), .LOAD_FIRST(LOAD_FIRST)) arb_i (
      .req(fu_bus_req), .busy(fu_busy), .is_pf(fu_is_pf), .gnt(fu_bus_gnt)
   );

   pf_sched_sat_ctr #(.W(CNT_W)) drop_ctr_i (
      .clk(clk), .rst_n(rst_n), .inc(drop_inc), .cnt(drop_cnt)
   );

   pf_sched_sat_ctr #(.W(CNT_W)) issue_ctr_i (
      .clk(clk), .rst_n(rst_n), .inc(issue_inc), .cnt(issue_cnt)
   );
endmodule

// File: rtl/pf_fetch_sched_chk.sv
module pf_fetch_sched_chk #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned NUM_FU = 4,
   parameter int unsigned PF_MAX = 2,
   parameter int unsigned CNT_W  = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cpu_op,
   input logic                       pf_req_valid,
   input logic                       pf_req_hit,
   input logic                       ld_miss_valid,
   input logic                       ld_miss_gnt,
   input logic [NUM_FU-1:0]          fu_start,
   input logic                       fu_start_pf,
   input logic [NUM_FU-1:0]          fu_busy,
   input logic [NUM_FU-1:0]          fu_is_pf,
   input logic [NUM_FU-1:0]          fu_bus_req,
   input logic [NUM_FU-1:0]          fu_bus_gnt,
   input logic [$clog2(DEPTH+1)-1:0] q_count,
   input logic [CNT_W-1:0]           drop_cnt,
   input logic [CNT_W-1:0]           issue_cnt
);
   // R5: prefetch units never exceed the cap
   p_pf_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fu_busy & fu_is_pf) <= PF_MAX);

   // R4: a prefetch start happens only in an idle CPU cycle without load miss
   p_drain_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_start != '0 && fu_start_pf) |-> (!cpu_op && !ld_miss_valid));

   // R8: start one-hot on a unit that is free, which then becomes busy
   p_start_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fu_start) && ((fu_start & fu_busy) == '0));
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_start != '0) |=> ((fu_busy & $past(fu_start)) == $past(fu_start)));

   // R9: bus grant one-hot, to a busy requester only
   p_gnt_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fu_bus_gnt) && ((fu_bus_gnt & ~(fu_bus_req & fu_busy)) == '0));

   // R6: a load miss with a free unit is granted
   p_ld_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_miss_valid && (fu_busy != '1)) |-> ld_miss_gnt);

   // R3: request at a full queue adds to the drop count
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == DEPTH && pf_req_valid && !pf_req_hit && drop_cnt != '1)
      |=> (drop_cnt != $past(drop_cnt)));

   // R10: counters never move backwards
   p_sat_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt >= $past(drop_cnt)) && (issue_cnt >= $past(issue_cnt)));

   // R2: a prefetch miss arriving at an empty queue does not start this cycle
   p_no_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == 0) |-> !(fu_start != '0 && fu_start_pf));
endmodule

bind pf_fetch_sched pf_fetch_sched_chk #(
   .DEPTH(DEPTH), .NUM_FU(NUM_FU), .PF_MAX(PF_MAX), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op),
   .pf_req_valid(pf_req_valid), .pf_req_hit(pf_req_hit),
   .ld_miss_valid(ld_miss_valid), .ld_miss_gnt(ld_miss_gnt),
   .fu_start(fu_start), .fu_start_pf(fu_start_pf),
   .fu_busy(fu_busy), .fu_is_pf(fu_is_pf),
   .fu_bus_req(fu_bus_req), .fu_bus_gnt(fu_bus_gnt),
   .q_count(q_count), .drop_cnt(drop_cnt), .issue_cnt(issue_cnt)
);

// File: tb/pf_fetch_sched_tb.sv
module pf_fetch_sched_tb_top;
   localparam int AW = 32;
   localparam int NF = 4;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_op = 1'b0, pf_req_valid = 1'b0, pf_req_hit = 1'b0;
   logic [AW-1:0] pf_req_addr = '0;
   logic          ld_miss_valid = 1'b0;
   logic [AW-1:0] ld_miss_addr = '0;
   logic          ld_miss_gnt;
   logic [AW-1:0] tag_chk_addr;
   logic          tag_chk_hit = 1'b0;
   logic [NF-1:0] fu_start;
   logic [AW-1:0] fu_start_addr;
   logic          fu_start_pf;
   logic [NF-1:0] fu_done = '0;
   logic [NF-1:0] fu_busy;
   logic [NF-1:0] fu_bus_req = '0;
   logic [NF-1:0] fu_bus_gnt;
   logic [CW-1:0] drop_cnt, issue_cnt;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pf_fetch_sched dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op),
      .pf_req_valid(pf_req_valid), .pf_req_hit(pf_req_hit), .pf_req_addr(pf_req_addr),
      .ld_miss_valid(ld_miss_valid), .ld_miss_addr(ld_miss_addr), .ld_miss_gnt(ld_miss_gnt),
      .tag_chk_addr(tag_chk_addr), .tag_chk_hit(tag_chk_hit),
      .fu_start(fu_start), .fu_start_addr(fu_start_addr), .fu_start_pf(fu_start_pf),
      .fu_done(fu_done), .fu_busy(fu_busy),
      .fu_bus_req(fu_bus_req), .fu_bus_gnt(fu_bus_gnt),
      .drop_cnt(drop_cnt), .issue_cnt(issue_cnt)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      cpu_op = 1'b0; pf_req_valid = 1'b0; pf_req_hit = 1'b0; pf_req_addr = '0;
      ld_miss_valid = 1'b0; ld_miss_addr = '0; tag_chk_hit = 1'b0;
      fu_done = '0; fu_bus_req = '0;
   endtask

   typedef struct packed {
      logic        cpu;
      logic        pfv;
      logic        pfh;
      logic [15:0] paddr;
      logic        ldv;
      logic [15:0] laddr;
      logic        thit;
      logic [3:0]  done;
      logic [3:0]  est;
      logic [15:0] eaddr;
      logic        epf;
      logic        egnt;
   } vec_t;

   // Each row is one cycle: drive inputs, expect fu_start / addr / pf / load grant.
   localparam vec_t VEC [15] = '{
      '{1'b1,1'b1,1'b0,16'h100,1'b0,16'h0,  1'b0,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R2/R4 queued, cpu busy
      '{1'b1,1'b1,1'b0,16'h140,1'b0,16'h0,  1'b0,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R4 head held
      '{1'b0,1'b1,1'b1,16'h180,1'b0,16'h0,  1'b0,4'h0,4'h1,16'h100,1'b1,1'b0}, // R11 head A; R1 hit ignored
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b0,4'h0,4'h2,16'h140,1'b1,1'b0}, // R11 then B
      '{1'b0,1'b1,1'b0,16'h1c0,1'b0,16'h0,  1'b0,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R1 nothing left from hit
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b0,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R5 cap reached
      '{1'b0,1'b0,1'b0,16'h0,  1'b1,16'h200,1'b0,4'h0,4'h4,16'h200,1'b0,1'b1}, // R6 load uses unit2
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b0,4'h1,4'h0,16'h0,  1'b0,1'b0}, // R8 release unit0
      '{1'b0,1'b0,1'b0,16'h0,  1'b1,16'h240,1'b0,4'h0,4'h1,16'h240,1'b0,1'b1}, // R6 load over head
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b1,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R7 head tag hit
      '{1'b0,1'b1,1'b0,16'h280,1'b0,16'h0,  1'b0,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R2 no bypass
      '{1'b0,1'b0,1'b0,16'h0,  1'b1,16'h2c0,1'b0,4'h0,4'h8,16'h2c0,1'b0,1'b1}, // R6 unit3
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b0,4'h0,4'h0,16'h0,  1'b0,1'b0}, // R4 no free unit
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b0,4'h2,4'h0,16'h0,  1'b0,1'b0}, // R8 release next edge
      '{1'b0,1'b0,1'b0,16'h0,  1'b0,16'h0,  1'b0,4'h0,4'h2,16'h280,1'b1,1'b0}  // R8 unit1 reused
   };

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      chk("R12 busy", 64'(fu_busy), 64'h0);
      chk("R12 drop", 64'(drop_cnt), 64'h0);
      chk("R12 issue", 64'(issue_cnt), 64'h0);
      fu_bus_req = '1; #1;
      chk("R12 gnt", 64'(fu_bus_gnt), 64'h0);
      fu_bus_req = '0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 start after reset", 64'(fu_start), 64'h0);

      foreach (VEC[k]) begin
         @(negedge clk);
         idle_in();
         cpu_op = VEC[k].cpu; pf_req_valid = VEC[k].pfv; pf_req_hit = VEC[k].pfh;
         pf_req_addr = AW'(VEC[k].paddr); ld_miss_valid = VEC[k].ldv;
         ld_miss_addr = AW'(VEC[k].laddr); tag_chk_hit = VEC[k].thit; fu_done = VEC[k].done;
         #5;
         chk($sformatf("R4/R6/R8 row%0d start", k), 64'(fu_start), 64'(VEC[k].est));
         chk($sformatf("R6 row%0d gnt", k), 64'(ld_miss_gnt), 64'(VEC[k].egnt));
         if (VEC[k].est != 0) begin
            chk($sformatf("R11 row%0d addr", k), 64'(fu_start_addr), 64'(VEC[k].eaddr));
            chk($sformatf("R6 row%0d pf", k), 64'(fu_start_pf), 64'(VEC[k].epf));
         end
      end
      @(negedge clk); idle_in(); cpu_op = 1'b1;
      chk("R10 issue after table", 64'(issue_cnt), 64'd3);
      chk("R7 drop after table", 64'(drop_cnt), 64'd1);

      // R9 bus arbitration: units 0,2,3 load; unit1 prefetch
      fu_bus_req = 4'b0010; #1; chk("R9 lone pf", 64'(fu_bus_gnt), 64'b0010);
      fu_bus_req = 4'b0011; #1; chk("R9 load over pf", 64'(fu_bus_gnt), 64'b0001);
      fu_bus_req = 4'b1110; #1; chk("R9 lowest load", 64'(fu_bus_gnt), 64'b0100);
      fu_done = '1;
      @(negedge clk); idle_in(); cpu_op = 1'b1;
      fu_bus_req = 4'b0001; #1; chk("R9 idle unit", 64'(fu_bus_gnt), 64'b0000);
      chk("R8 all free", 64'(fu_busy), 64'h0);

      // R2 no bypass with free units
      @(negedge clk); idle_in(); pf_req_valid = 1'b1; pf_req_addr = 32'h300; #5;
      chk("R2 no same-cycle start", 64'(fu_start), 64'h0);
      @(negedge clk); idle_in(); #5;
      chk("R2 start next cycle", 64'(fu_start), 64'h1);
      chk("R2 addr", 64'(fu_start_addr), 64'h300);
      @(negedge clk); idle_in(); cpu_op = 1'b1; fu_done = 4'h1;

      // R3 overflow: ten misses with CPU busy
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); idle_in(); cpu_op = 1'b1;
         pf_req_valid = 1'b1; pf_req_addr = AW'(32'h1000 + i * 64);
      end
      @(negedge clk); idle_in(); cpu_op = 1'b1;
      chk("R3 two discarded", 64'(drop_cnt), 64'd3);
      // R11 drain order of the eight kept
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); idle_in(); #5;
         chk("R11 order start", 64'(fu_start), 64'h1);
         chk("R11 order addr", 64'(fu_start_addr), 64'(32'h1000 + i * 64));
         @(negedge clk); idle_in(); cpu_op = 1'b1; fu_done = 4'h1;
      end
      @(negedge clk); idle_in(); #5;
      chk("R3 discarded never start", 64'(fu_start), 64'h0);
      chk("R10 issue", 64'(issue_cnt), 64'd12);

      // R3/R7 collision: full queue, new miss and head tag hit together
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); idle_in(); cpu_op = 1'b1;
         pf_req_valid = 1'b1; pf_req_addr = AW'(32'h2000 + i * 64);
      end
      @(negedge clk); idle_in();
      pf_req_valid = 1'b1; pf_req_addr = 32'h3000; tag_chk_hit = 1'b1; #5;
      chk("R7 tag hit no start", 64'(fu_start), 64'h0);
      chk("R7 recheck addr", 64'(tag_chk_addr), 64'h2000);
      @(negedge clk); idle_in(); cpu_op = 1'b1;
      chk("R3 R7 double drop", 64'(drop_cnt), 64'd5);

      // R10 saturation
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); idle_in(); cpu_op = 1'b1;
         pf_req_valid = 1'b1; pf_req_addr = AW'(i);
      end
      @(negedge clk); idle_in(); cpu_op = 1'b1;
      chk("R10 drop saturates", 64'(drop_cnt), 64'hff);
      @(negedge clk); idle_in(); cpu_op = 1'b1; pf_req_valid = 1'b1;
      @(negedge clk); idle_in();
      chk("R10 stays at max", 64'(drop_cnt), 64'hff);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule